// File: doc/BRIEF.md
# Shared Add, Subtract and Compare Datapath

This block is the integer arithmetic core of a 64-bit execution stage. It is purely combinational. One carry-propagate adder computes `(A xor I) + B + C` for every add and subtract flavour. The decoder picks the inversion mask `I` (all zeros or all ones), the source of `B` (operand B, constant zero or constant all-ones) and the carry-in `C` (zero, one or the stored carry flag). With these three selects, plain add, subtract-from, extended forms, add-minus-one and negate all reach the same hardware.

Compares run through the same adder. When compare mode is raised, the block overrides the decoder selects and computes `~A + B + 1`, which equals `B - A`. It then builds a four-bit condition field:

- Equality comes from a direct comparison of the two operands.
- Less-than and greater-than come from three things: the difference's sign bit, the carry out of the compared width, and the two operand sign bits.

A signed flag chooses signed or unsigned ordering. A width flag chooses 32-bit or 64-bit comparison. Outside compare mode, the condition field describes the sum against zero, as record-form instructions need. In both modes the summary-overflow flag is copied into the field.

Top module: `addcmp_unit`

## Requirements
- R1: `sum` equals `(opa xor I) + B + C` modulo 2^64, where `I` is all ones when `inv_a`=1 and all zeros when `inv_a`=0.
- R2: `b_src` selects B: 0 gives `opb`, 1 gives zero, 2 gives all ones, 3 gives `opb`.
- R3: `cin_src` selects C: 0 gives 0, 1 gives 1, 2 gives `ca_in`, 3 gives 0.
- R4: `ca` is the carry out of bit 63 of the sum. `ov` is set when the two adder inputs share a sign bit 63 and the sum's bit 63 differs from it.
- R5: `ca32` is the carry out of bit 31. `ov32` is the same signed-overflow rule applied at bit 31.
- R6: When `cmp_en`=1, the adder computes `~opa + opb + 1` whatever `inv_a`, `b_src` and `cin_src` hold, so `sum` is `opb - opa`.
- R7: In compare mode, EQ is set exactly when the operands are equal over the compared width.
- R8: In an unsigned compare, LT means opa < opb and GT means opa > opb, both taken as unsigned values of the compared width.
- R9: In a signed compare, LT and GT give the same ordering for two's-complement values of the compared width.
- R10: When `cmp_wide`=0, only bits 31..0 of the operands affect `cond[3:1]`.
- R11: In compare mode, exactly one of LT, GT and EQ is set.
- R12: When `cmp_en`=0, `cond[3:1]` describes `sum` as a signed 64-bit value: LT if negative, EQ if zero, GT otherwise.
- R13: `cond[0]` equals `so_in` in both modes. The field bit order is `cond[3]`=LT, `cond[2]`=GT, `cond[1]`=EQ, `cond[0]`=SO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 64 | First operand (A) |
| opb | input | 64 | Second operand (B source) |
| inv_a | input | 1 | Invert A before the add |
| b_src | input | 2 | B source select |
| cin_src | input | 2 | Carry-in source select |
| ca_in | input | 1 | Stored carry flag |
| so_in | input | 1 | Stored summary-overflow flag |
| cmp_en | input | 1 | Compare mode |
| cmp_wide | input | 1 | 1: 64-bit compare, 0: 32-bit compare |
| cmp_signed | input | 1 | 1: signed ordering, 0: unsigned |
| sum | output | 64 | Adder result |
| ca | output | 1 | Carry out of bit 63 |
| ca32 | output | 1 | Carry out of bit 31 |
| ov | output | 1 | Signed overflow at 64 bits |
| ov32 | output | 1 | Signed overflow at 32 bits |
| cond | output | 4 | LT, GT, EQ, SO |

## Verification
Adds are tried near the two sign boundaries and the all-ones carry boundary. This separates the carry and overflow flags at 32 and 64 bits, and catches a swapped or missing constant selection. Compares use pairs that order differently when taken as signed or as unsigned, such as -1 against 1. They also use pairs whose upper halves differ while the lower halves match, so a wrong width or signedness choice shows as a wrong LT/GT/EQ bit. Compare mode is driven with deliberately wrong decoder selects, to show that it overrides them. Record-form cases produce negative, zero and positive sums.

// File: rtl/addcmp_pkg.sv
package addcmp_pkg;

    typedef enum logic [1:0] {
        BSRC_OPND = 2'd0,
        BSRC_ZERO = 2'd1,
        BSRC_ONES = 2'd2,
        BSRC_ALT  = 2'd3
    } bsrc_e;

    typedef enum logic [1:0] {
        CSRC_ZERO = 2'd0,
        CSRC_ONE  = 2'd1,
        CSRC_FLAG = 2'd2,
        CSRC_NONE = 2'd3
    } csrc_e;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cond_t;

    // Signed overflow: inputs agree in sign, result disagrees.
    function automatic logic sgn_ovf(input logic xs, input logic ys, input logic rs);
        return (xs == ys) && (rs != xs);
    endfunction

endpackage

// File: rtl/addcmp_operand_sel.sv
module addcmp_operand_sel
    import addcmp_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             inv_a,
    input  logic [1:0]       b_src,
    input  logic [1:0]       cin_src,
    input  logic             ca_in,
    input  logic             cmp_en,
    output logic [WIDTH-1:0] add_x,
    output logic [WIDTH-1:0] add_y,
    output logic             add_c
);

    bsrc_e bsel;
    csrc_e csel;

    always_comb begin
        bsel = bsrc_e'(b_src);
        csel = csrc_e'(cin_src);

        if (cmp_en) begin
            // compare: ~A + B + 1
            add_x = ~opa;
            add_y = opb;
            add_c = 1'b1;
        end else begin
            add_x = inv_a ? ~opa : opa;
            unique case (bsel)
                BSRC_ZERO: add_y = '0;
                BSRC_ONES: add_y = '1;
                default:   add_y = opb;
            endcase
            unique case (csel)
                CSRC_ONE:  add_c = 1'b1;
                CSRC_FLAG: add_c = ca_in;
                default:   add_c = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/addcmp_adder.sv
module addcmp_adder
    import addcmp_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] add_x,
    input  logic [WIDTH-1:0] add_y,
    input  logic             add_c,
    output logic [WIDTH-1:0] sum,
    output logic             ca,
    output logic             ca32,
    output logic             ov,
    output logic             ov32
);

    localparam int unsigned HALF = WIDTH / 2;

    logic [HALF:0]       lo_sum;
    logic [WIDTH-HALF:0] hi_sum;

    always_comb begin
        lo_sum = {1'b0, add_x[HALF-1:0]} + {1'b0, add_y[HALF-1:0]} + {{HALF{1'b0}}, add_c};
        hi_sum = {1'b0, add_x[WIDTH-1:HALF]} + {1'b0, add_y[WIDTH-1:HALF]}
               + {{(WIDTH-HALF){1'b0}}, lo_sum[HALF]};
        sum  = {hi_sum[WIDTH-HALF-1:0], lo_sum[HALF-1:0]};
        ca   = hi_sum[WIDTH-HALF];
        ca32 = lo_sum[HALF];
        ov   = sgn_ovf(add_x[WIDTH-1], add_y[WIDTH-1], sum[WIDTH-1]);
        ov32 = sgn_ovf(add_x[HALF-1], add_y[HALF-1], sum[HALF-1]);
    end

endmodule

// File: rtl/addcmp_cond.sv
module addcmp_cond
    import addcmp_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic [WIDTH-1:0] sum,
    input  logic             ca,
    input  logic             ca32,
    input  logic             so_in,
    input  logic             cmp_en,
    input  logic             cmp_wide,
    input  logic             cmp_signed,
    output cond_t            cond
);

    localparam int unsigned HALF = WIDTH / 2;

    logic eq_w, eq_h;
    logic a_msb, b_msb, r_msb, cy, eq_sel;

    always_comb begin
        eq_w = (opa == opb);
        eq_h = (opa[HALF-1:0] == opb[HALF-1:0]);

        if (cmp_wide) begin
            a_msb  = opa[WIDTH-1];
            b_msb  = opb[WIDTH-1];
            r_msb  = sum[WIDTH-1];
            cy     = ca;
            eq_sel = eq_w;
        end else begin
            a_msb  = opa[HALF-1];
            b_msb  = opb[HALF-1];
            r_msb  = sum[HALF-1];
            cy     = ca32;
            eq_sel = eq_h;
        end

        cond.so = so_in;
        if (cmp_en) begin
            cond.eq = eq_sel;
            if (cmp_signed && (a_msb != b_msb)) begin
                // differing signs: the negative one is smaller
                cond.lt = a_msb;
                cond.gt = ~a_msb;
            end else if (cmp_signed) begin
                // same signs: B - A cannot overflow
                cond.lt = ~r_msb & ~eq_sel;
                cond.gt = r_msb;
            end else begin
                // carry out of B - A means B >= A
                cond.lt = cy & ~eq_sel;
                cond.gt = ~cy;
            end
        end else begin
            cond.eq = (sum == '0);
            cond.lt = sum[WIDTH-1];
            cond.gt = ~sum[WIDTH-1] & (sum != '0);
        end
    end

endmodule

// File: rtl/addcmp_unit.sv
module addcmp_unit
    import addcmp_pkg::*;
#(
    parameter int unsigned WIDTH = 64
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             inv_a,
    input  logic [1:0]       b_src,
    input  logic [1:0]       cin_src,
    input  logic             ca_in,
    input  logic             so_in,
    input  logic             cmp_en,
    input  logic             cmp_wide,
    input  logic             cmp_signed,
    output logic [WIDTH-1:0] sum,
    output logic             ca,
    output logic             ca32,
    output logic             ov,
    output logic             ov32,
    output logic [3:0]       cond
);

    localparam int unsigned HALF = WIDTH / 2;

    logic [WIDTH-1:0] add_x, add_y;
    logic             add_c;
    cond_t            cfield;

    addcmp_operand_sel #(.WIDTH(WIDTH)) u_sel (
        .opa(opa), .opb(opb), .inv_a(inv_a), .b_src(b_src),
        .cin_src(cin_src), .ca_in(ca_in), .cmp_en(cmp_en),
        .add_x(add_x), .add_y(add_y), .add_c(add_c)
    );

    addcmp_adder #(.WIDTH(WIDTH)) u_add (
        .add_x(add_x), .add_y(add_y), .add_c(add_c),
        .sum(sum), .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32)
    );

    addcmp_cond #(.WIDTH(WIDTH)) u_cond (
        .opa(opa), .opb(opb), .sum(sum), .ca(ca), .ca32(ca32),
        .so_in(so_in), .cmp_en(cmp_en), .cmp_wide(cmp_wide),
        .cmp_signed(cmp_signed), .cond(cfield)
    );

    assign cond = cfield;

    always_comb begin
        if (cmp_en) begin
            assert_cmp_onehot_R11: assert ($countones(cond[3:1]) == 1)
                else $error("compare produced %b", cond[3:1]);
        end
        if (cmp_en && cmp_wide && cond[1]) begin
            assert_eq_zero_diff_R7: assert (sum == '0)
                else $error("EQ with nonzero difference");
        end
        if (cmp_en && !cmp_signed && !cmp_wide && cond[3]) begin
            assert_ult_carry_R8: assert (ca32)
                else $error("unsigned LT without carry");
        end
        if (!cmp_en && !inv_a && b_src == 2'd1 && cin_src == 2'd0) begin
            assert_pass_a_R2: assert (sum == opa && !ca && !ov)
                else $error("A + 0 + 0 altered A");
        end
        if (cmp_en && cmp_wide && !cmp_signed && cond[2]) begin
            assert_ugt_nocarry_R6: assert (!ca)
                else $error("unsigned GT with carry");
        end
    end

endmodule

// File: tb/addcmp_unit_test.sv
module addcmp_unit_test;

    localparam int unsigned W = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic [W-1:0] opa, opb, sum;
    logic inv_a, ca_in, so_in, cmp_en, cmp_wide, cmp_signed;
    logic [1:0] b_src, cin_src;
    logic ca, ca32, ov, ov32;
    logic [3:0] cond;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    addcmp_unit #(.WIDTH(W)) uut (
        .opa(opa), .opb(opb), .inv_a(inv_a), .b_src(b_src), .cin_src(cin_src),
        .ca_in(ca_in), .so_in(so_in), .cmp_en(cmp_en), .cmp_wide(cmp_wide),
        .cmp_signed(cmp_signed), .sum(sum), .ca(ca), .ca32(ca32), .ov(ov),
        .ov32(ov32), .cond(cond)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic inv,
                         input logic [1:0] bs, input logic [1:0] cs, input logic cin,
                         input logic so, input logic ce, input logic wide, input logic sg);
        @(negedge clk);
        opa = a; opb = b; inv_a = inv; b_src = bs; cin_src = cs; ca_in = cin;
        so_in = so; cmp_en = ce; cmp_wide = wide; cmp_signed = sg;
        @(posedge clk);
        #1;
    endtask

    // Add: compute expected arithmetic from the stated formula.
    task automatic add_case(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic inv, input logic [1:0] bs, input logic [1:0] cs,
                            input logic cin);
        logic [W-1:0] x, y;
        logic c;
        logic [W:0] full;
        logic [32:0] low;
        logic [W:0] s65;
        logic [32:0] s33;
        logic [3:0] ec;
        drive(a, b, inv, bs, cs, cin, 1'b0, 1'b0, 1'b1, 1'b0);
        x = inv ? ~a : a;
        y = (bs == 2'd1) ? '0 : (bs == 2'd2) ? '1 : b;
        c = (cs == 2'd1) ? 1'b1 : (cs == 2'd2) ? cin : 1'b0;
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
        low  = {1'b0, x[31:0]} + {1'b0, y[31:0]} + {32'd0, c};
        s65  = {x[W-1], x} + {y[W-1], y} + {{W{1'b0}}, c};
        s33  = {x[31], x[31:0]} + {y[31], y[31:0]} + {32'd0, c};
        ec = {($signed(full[W-1:0]) < 0), ($signed(full[W-1:0]) > 0),
              (full[W-1:0] == '0), 1'b0};
        chk(req, "sum", sum, full[W-1:0]);
        chk("R4", "ca", {63'd0, ca}, {63'd0, full[W]});
        chk("R4", "ov", {63'd0, ov}, {63'd0, s65[W] ^ s65[W-1]});
        chk("R5", "ca32", {63'd0, ca32}, {63'd0, low[32]});
        chk("R5", "ov32", {63'd0, ov32}, {63'd0, s33[32] ^ s33[31]});
        chk("R12", "cond", {60'd0, cond}, {60'd0, ec});
    endtask

    // Compare: expected ordering from native comparisons.
    task automatic cmp_case(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                            input logic wide, input logic sg, input logic so);
        logic lt, gt, eq;
        drive(a, b, 1'b0, 2'd1, 2'd0, 1'b0, so, 1'b1, wide, sg);
        if (wide) begin
            eq = (a == b);
            lt = sg ? ($signed(a) < $signed(b)) : (a < b);
        end else begin
            eq = (a[31:0] == b[31:0]);
            lt = sg ? ($signed(a[31:0]) < $signed(b[31:0])) : (a[31:0] < b[31:0]);
        end
        gt = !lt && !eq;
        chk(req, "cond", {60'd0, cond}, {60'd0, lt, gt, eq, so});
        chk("R6", "diff", sum, b - a);
    endtask

    task automatic t_idle;
        drive('0, '0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R12", "idle sum", sum, '0);
        chk("R12", "idle cond", {60'd0, cond}, {60'd0, 4'b0010});
    endtask

    task automatic t_add;
        add_case("R1", 64'd5, 64'd7, 1'b0, 2'd0, 2'd0, 1'b0);
        add_case("R1", 64'h7fff_ffff_ffff_ffff, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0);
        add_case("R4", 64'hffff_ffff_ffff_ffff, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0);
        add_case("R4", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0, 2'd0, 2'd0, 1'b0);
    endtask

    task automatic t_sub;
        add_case("R1", 64'd9, 64'd4, 1'b1, 2'd0, 2'd1, 1'b0);
        add_case("R1", 64'd3, 64'd3, 1'b1, 2'd0, 2'd1, 1'b0);
        add_case("R1", 64'h1234, 64'd0, 1'b1, 2'd1, 2'd1, 1'b0);
    endtask

    task automatic t_selects;
        add_case("R2", 64'd10, 64'd99, 1'b0, 2'd2, 2'd0, 1'b0);
        add_case("R2", 64'd10, 64'd99, 1'b0, 2'd3, 2'd0, 1'b0);
        add_case("R2", 64'd10, 64'd99, 1'b0, 2'd1, 2'd0, 1'b0);
        add_case("R3", 64'd10, 64'd0, 1'b0, 2'd2, 2'd2, 1'b1);
        add_case("R3", 64'd10, 64'd5, 1'b0, 2'd0, 2'd2, 1'b0);
        add_case("R3", 64'd10, 64'd5, 1'b0, 2'd0, 2'd3, 1'b1);
    endtask

    task automatic t_half;
        add_case("R5", 64'h0000_0000_7fff_ffff, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0);
        add_case("R5", 64'h0000_0000_ffff_ffff, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0);
    endtask

    task automatic t_cmp_override;
        // wrong decoder selects must not matter in compare mode
        drive(64'd3, 64'd10, 1'b0, 2'd2, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        chk("R6", "override diff", sum, 64'd7);
        chk("R6", "override cond", {60'd0, cond}, {60'd0, 4'b1000});
    endtask

    task automatic t_cmp;
        cmp_case("R8", 64'hffff_ffff_ffff_ffff, 64'd1, 1'b1, 1'b0, 1'b0);
        cmp_case("R9", 64'hffff_ffff_ffff_ffff, 64'd1, 1'b1, 1'b1, 1'b0);
        cmp_case("R7", 64'h55aa, 64'h55aa, 1'b1, 1'b1, 1'b0);
        cmp_case("R9", 64'd5, 64'd20, 1'b1, 1'b1, 1'b0);
        cmp_case("R9", 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0001, 1'b1, 1'b1, 1'b0);
        cmp_case("R8", 64'd20, 64'd5, 1'b1, 1'b0, 1'b0);
        cmp_case("R13", 64'd1, 64'd2, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_cmp32;
        cmp_case("R10", 64'hdead_0000_0000_0005, 64'h1234_0000_0000_0005, 1'b0, 1'b0, 1'b0);
        cmp_case("R10", 64'h0000_0001_ffff_ffff, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 1'b0);
        cmp_case("R10", 64'h0000_0001_ffff_ffff, 64'h0000_0000_0000_0001, 1'b0, 1'b0, 1'b1);
        cmp_case("R7", 64'hdead_0000_0000_0005, 64'h1234_0000_0000_0005, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic t_onehot;
        for (int i = 0; i < 16; i++) begin
            logic [W-1:0] a, b;
            a = {32'h0, 32'h8000_0000} * (i & 3) + 64'(i);
            b = 64'h7fff_ffff_ffff_fff0 + 64'(i * 5);
            drive(a, b, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1, i[0], i[1]);
            chk("R11", "onehot", {63'd0, ($countones(cond[3:1]) == 1)}, 64'd1);
        end
    endtask

    task automatic t_so;
        add_case("R13", 64'd1, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0);
        drive(64'd1, 64'd1, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk("R13", "so record", {63'd0, cond[0]}, 64'd1);
        add_case("R12", 64'd0, 64'd5, 1'b1, 2'd0, 2'd0, 1'b0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        opa = '0; opb = '0; inv_a = 0; b_src = 0; cin_src = 0; ca_in = 0;
        so_in = 0; cmp_en = 0; cmp_wide = 1; cmp_signed = 0;
        t_idle();
        t_add();
        t_sub();
        t_selects();
        t_half();
        t_cmp_override();
        t_cmp();
        t_cmp32();
        t_onehot();
        t_so();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule